// File: doc/BRIEF.md
# Two-Wide Register Renamer with Free Pool

This block renames up to two instructions per clock into one shared physical register file that holds both committed and in-flight values. Each lane's two architectural source numbers are translated to physical numbers through a mapping table. A lane that writes a destination draws a fresh physical register from a free pool. The table is then updated to point at it, and the physical register that the destination pointed to before is reported. Retirement logic later hands those superseded registers back through two return ports, and they rejoin the pool.

Both lanes are renamed as one group. When the second lane reads or writes the register that the first lane writes, it sees the first lane's new allocation. If the pool holds fewer registers than the group needs, the whole group is held back and nothing changes. Renamed results are registered and appear one clock after the group is accepted. Only register operands are renamed.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are free.
- R2: The pool hands out registers first-in first-out. After reset the first allocations are NUM_ARCH, NUM_ARCH+1, and so on in ascending order, with lane 0 served before lane 1 within a group.
- R3: An accepted group's results appear on the outputs on the clock after acceptance. Bit k of `out_valid` is set when lane k was valid.
- R4: For every lane that writes, `out_pold` gives the physical register the destination mapped to before this rename.
- R5: A rename in a later group sees the mappings written by earlier groups.
- R6: A lane 1 source equal to lane 0's written destination receives lane 0's new physical register rather than the table entry.
- R7: When both lanes write the same destination, lane 1's `out_pold` is lane 0's new register, and the table keeps lane 1's allocation.
- R8: A lane that is valid with `in_wr` low consumes no free register, so the next allocation goes to the next writing lane.
- R9: When the pool holds fewer registers than the group's writing lanes, `grp_ready` is low. No lane is output, and the mapping table and pool are left unchanged.
- R10: Registers returned through `ret_valid`/`ret_preg` join the tail of the pool, lane 0 before lane 1, and are handed out after every register already free.
- R11: `grp_ready` reflects the pool as it stood at the start of the cycle. A register returned in a cycle can be allocated from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Lane valid, bit k for lane k |
| in_src1 | input | 2*AW | First source architectural number, lane k at bits k*AW |
| in_src2 | input | 2*AW | Second source architectural number |
| in_dst | input | 2*AW | Destination architectural number |
| in_wr | input | 2 | Lane writes a destination |
| grp_ready | output | 1 | Group can be accepted this cycle |
| out_valid | output | 2 | Renamed lane valid |
| out_has_dst | output | 2 | Renamed lane has a new destination |
| out_psrc1 | output | 2*PW | First source physical number |
| out_psrc2 | output | 2*PW | Second source physical number |
| out_pdst | output | 2*PW | Newly allocated physical register |
| out_pold | output | 2*PW | Superseded physical register of the destination |
| ret_valid | input | 2 | Return port valid |
| ret_preg | input | 2*PW | Physical register being returned |

## Verification
Each renamed result is due on the first rising edge after the group is presented. The bench drives a group on a falling edge, checks `grp_ready` combinationally in that same half cycle, and samples the outputs on the following falling edge. A returned register is free from the edge that takes the return. The bench therefore checks that a group presented in the same cycle as the return still stalls, and that the group in the next cycle receives that register. Expected numbers come from tracking pool order and table contents by hand through the sequence.

// File: rtl/renamer_pkg.sv
package renamer_pkg;
  localparam int LANES = 2;

  function automatic int clog2_min1(input int n);
    int r;
    r = $clog2(n);
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NRD      = 6,
  localparam int AW = renamer_pkg::clog2_min1(NUM_ARCH),
  localparam int PW = renamer_pkg::clog2_min1(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRD*AW-1:0]   rd_idx,
  output logic [NRD*PW-1:0]   rd_val,
  input  logic [1:0]          wr_en,
  input  logic [2*AW-1:0]     wr_idx,
  input  logic [2*PW-1:0]     wr_val
);
  logic [PW-1:0] tbl [NUM_ARCH];

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_val[g*PW +: PW] = tbl[rd_idx[g*AW +: AW]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ARCH; i++) tbl[i] <= PW'(i);
    end else begin
      if (wr_en[0]) tbl[wr_idx[0 +: AW]] <= wr_val[0 +: PW];
      if (wr_en[1]) tbl[wr_idx[AW +: AW]] <= wr_val[PW +: PW];
    end
  end

  // R7: both writes to one entry leave lane 1's value
  p_lane1_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en == 2'b11 && wr_idx[0 +: AW] == wr_idx[AW +: AW])
    |=> tbl[$past(wr_idx[AW +: AW])] == $past(wr_val[PW +: PW]));
endmodule

// File: rtl/free_pool.sv
module free_pool #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW    = renamer_pkg::clog2_min1(NUM_PHYS),
  localparam int NFREE = NUM_PHYS - NUM_ARCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      pop_n,
  input  logic [1:0]      push_en,
  input  logic [2*PW-1:0] push_reg,
  output logic [PW-1:0]   head0,
  output logic [PW-1:0]   head1,
  output logic [PW:0]     count
);
  logic [PW-1:0] slot [NUM_PHYS];
  logic [PW-1:0] hd, tl;
  logic [PW-1:0] tl1;
  logic [1:0]    push_n;

  assign push_n = {1'b0, push_en[0]} + {1'b0, push_en[1]};
  assign tl1    = tl + PW'(push_en[0]);
  assign head0  = slot[hd];
  assign head1  = slot[hd + PW'(1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slot[i] <= (i < NFREE) ? PW'(i + NUM_ARCH) : '0;
    end else begin
      if (push_en[0]) slot[tl]  <= push_reg[0 +: PW];
      if (push_en[1]) slot[tl1] <= push_reg[PW +: PW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hd    <= '0;
      tl    <= PW'(NFREE);
      count <= (PW+1)'(NFREE);
    end else begin
      hd    <= hd + PW'(pop_n);
      tl    <= tl + PW'(push_n);
      count <= count + (PW+1)'(push_n) - (PW+1)'(pop_n);
    end
  end

  // R9: never hand out more registers than are held
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    (PW+1)'(pop_n) <= count);
  // R10: returns never push the pool past its capacity
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (int'(count) + int'(push_n) - int'(pop_n)) <= NUM_PHYS);
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = renamer_pkg::clog2_min1(NUM_ARCH),
  localparam int PW = renamer_pkg::clog2_min1(NUM_PHYS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      in_valid,
  input  logic [2*AW-1:0] in_src1,
  input  logic [2*AW-1:0] in_src2,
  input  logic [2*AW-1:0] in_dst,
  input  logic [1:0]      in_wr,
  output logic            grp_ready,
  output logic [1:0]      out_valid,
  output logic [1:0]      out_has_dst,
  output logic [2*PW-1:0] out_psrc1,
  output logic [2*PW-1:0] out_psrc2,
  output logic [2*PW-1:0] out_pdst,
  output logic [2*PW-1:0] out_pold,
  input  logic [1:0]      ret_valid,
  input  logic [2*PW-1:0] ret_preg
);
  localparam int NRD = 3 * renamer_pkg::LANES;

  logic [1:0]        need;
  logic [1:0]        need_n;
  logic [1:0]        pop_n;
  logic [1:0]        map_we;
  logic [PW:0]       pool_cnt;
  logic [PW-1:0]     head0, head1;
  logic [PW-1:0]     new0, new1;
  logic [NRD*AW-1:0] rd_idx;
  logic [NRD*PW-1:0] rd_val;
  logic [PW-1:0]     s1_0, s2_0, od_0, s1_1, s2_1, od_1;
  logic [PW-1:0]     s1_1b, s2_1b, od_1b;

  assign need      = in_valid & in_wr;
  assign need_n    = {1'b0, need[0]} + {1'b0, need[1]};
  assign grp_ready = pool_cnt >= (PW+1)'(need_n);
  assign pop_n     = grp_ready ? need_n : 2'd0;
  assign map_we    = grp_ready ? need : 2'b00;
  assign new0      = head0;
  assign new1      = need[0] ? head1 : head0;

  assign rd_idx = {in_dst[AW +: AW], in_src2[AW +: AW], in_src1[AW +: AW],
                   in_dst[0 +: AW],  in_src2[0 +: AW],  in_src1[0 +: AW]};
  assign {od_1, s2_1, s1_1, od_0, s2_0, s1_0} = rd_val;

  // intra-group forwarding from lane 0's new destination
  assign s1_1b = (need[0] && in_src1[AW +: AW] == in_dst[0 +: AW]) ? new0 : s1_1;
  assign s2_1b = (need[0] && in_src2[AW +: AW] == in_dst[0 +: AW]) ? new0 : s2_1;
  assign od_1b = (need[0] && in_dst[AW +: AW]  == in_dst[0 +: AW]) ? new0 : od_1;

  rename_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NRD(NRD)) i_map (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (rd_idx),
    .rd_val (rd_val),
    .wr_en  (map_we),
    .wr_idx (in_dst),
    .wr_val ({new1, new0})
  );

  free_pool #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_pool (
    .clk      (clk),
    .rst      (rst),
    .pop_n    (pop_n),
    .push_en  (ret_valid),
    .push_reg (ret_preg),
    .head0    (head0),
    .head1    (head1),
    .count    (pool_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= '0;
      out_has_dst <= '0;
      out_psrc1   <= '0;
      out_psrc2   <= '0;
      out_pdst    <= '0;
      out_pold    <= '0;
    end else begin
      out_valid   <= grp_ready ? in_valid : 2'b00;
      out_has_dst <= grp_ready ? need : 2'b00;
      out_psrc1   <= {s1_1b, s1_0};
      out_psrc2   <= {s2_1b, s2_0};
      out_pdst    <= {new1, new0};
      out_pold    <= {od_1b, od_0};
    end
  end

  // R9: a held group produces no output next cycle
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (!grp_ready) |=> (out_valid == 2'b00));
  // R2: two allocations in one group are distinct registers
  p_distinct_r2: assert property (@(posedge clk) disable iff (rst)
    (out_has_dst == 2'b11) |-> (out_pdst[0 +: PW] != out_pdst[PW +: PW]));
  // R6: lane 1 source forwarded from lane 0's allocation
  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (grp_ready && need[0] && in_valid[1] && in_src1[AW +: AW] == in_dst[0 +: AW])
    |=> (out_psrc1[PW +: PW] == out_pdst[0 +: PW]));
  // R7: lane 1 old mapping is lane 0's new register on a shared destination
  p_same_dst_r7: assert property (@(posedge clk) disable iff (rst)
    (grp_ready && need == 2'b11 && in_dst[0 +: AW] == in_dst[AW +: AW])
    |=> (out_pold[PW +: PW] == out_pdst[0 +: PW]));
endmodule

// File: tb/test_reg_renamer.sv
module test_reg_renamer;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = 3;
  localparam int PW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      in_valid = '0;
  logic [2*AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [1:0]      in_wr = '0;
  logic            grp_ready;
  logic [1:0]      out_valid, out_has_dst;
  logic [2*PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold;
  logic [1:0]      ret_valid = '0;
  logic [2*PW-1:0] ret_preg = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  reg_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP)) i_reg_renamer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src1(in_src1),
    .in_src2(in_src2), .in_dst(in_dst), .in_wr(in_wr), .grp_ready(grp_ready),
    .out_valid(out_valid), .out_has_dst(out_has_dst), .out_psrc1(out_psrc1),
    .out_psrc2(out_psrc2), .out_pdst(out_pdst), .out_pold(out_pold),
    .ret_valid(ret_valid), .ret_preg(ret_preg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lane(input int l, input bit v, input int s1, input int s2,
                      input int d, input bit w);
    in_valid[l]          = v;
    in_src1[l*AW +: AW]  = AW'(s1);
    in_src2[l*AW +: AW]  = AW'(s2);
    in_dst[l*AW +: AW]   = AW'(d);
    in_wr[l]             = w;
  endtask

  task automatic clear_in();
    in_valid = '0; in_wr = '0; in_src1 = '0; in_src2 = '0; in_dst = '0;
    ret_valid = '0; ret_preg = '0;
  endtask

  // group set up before call on a falling edge; wait for registered result
  task automatic fire(input string req, input bit exp_ready);
    #1;
    chk({req, " grp_ready"}, int'(grp_ready), int'(exp_ready));
    @(negedge clk);
    clear_in();
  endtask

  function automatic int f(input logic [2*PW-1:0] v, input int l);
    return int'(v[l*PW +: PW]);
  endfunction

  task automatic t_reset_and_first();
    chk("R3 out_valid at reset", int'(out_valid), 0);
    chk("R1 grp_ready at reset", int'(grp_ready), 1);
    lane(0, 1, 3, 5, 2, 1);
    fire("R1", 1'b1);
    chk("R3 out_valid", int'(out_valid), 1);
    chk("R1 psrc1 identity", f(out_psrc1, 0), 3);
    chk("R1 psrc2 identity", f(out_psrc2, 0), 5);
    chk("R2 first alloc", f(out_pdst, 0), 8);
    chk("R4 old mapping", f(out_pold, 0), 2);
  endtask

  task automatic t_bypass();
    lane(0, 1, 2, 0, 2, 1);
    lane(1, 1, 2, 2, 4, 1);
    fire("R6", 1'b1);
    chk("R3 out_valid both", int'(out_valid), 3);
    chk("R5 lane0 sees earlier map", f(out_psrc1, 0), 8);
    chk("R4 lane0 old", f(out_pold, 0), 8);
    chk("R2 lane0 alloc", f(out_pdst, 0), 9);
    chk("R6 lane1 src1 bypass", f(out_psrc1, 1), 9);
    chk("R6 lane1 src2 bypass", f(out_psrc2, 1), 9);
    chk("R2 lane1 alloc", f(out_pdst, 1), 10);
    chk("R4 lane1 old", f(out_pold, 1), 4);
  endtask

  task automatic t_same_dst();
    lane(0, 1, 0, 0, 6, 1);
    lane(1, 1, 6, 1, 6, 1);
    fire("R7", 1'b1);
    chk("R7 lane0 old", f(out_pold, 0), 6);
    chk("R7 lane1 old is lane0 new", f(out_pold, 1), 11);
    chk("R6 lane1 src from lane0", f(out_psrc1, 1), 11);
    chk("R7 lane1 alloc", f(out_pdst, 1), 12);
    lane(0, 1, 6, 4, 0, 0);
    fire("R7", 1'b1);
    chk("R7 table keeps lane1", f(out_psrc1, 0), 12);
    chk("R5 later group sees map", f(out_psrc2, 0), 10);
    chk("R8 no dst flag", int'(out_has_dst), 0);
  endtask

  task automatic t_no_write_lane();
    lane(0, 1, 2, 3, 0, 0);
    lane(1, 1, 5, 0, 5, 1);
    fire("R8", 1'b1);
    chk("R8 lane0 src", f(out_psrc1, 0), 9);
    chk("R8 lane1 gets next free", f(out_pdst, 1), 13);
    chk("R8 out_has_dst", int'(out_has_dst), 2);
  endtask

  task automatic t_exhaust_stall();
    lane(0, 1, 0, 0, 1, 1);
    lane(1, 1, 0, 0, 3, 1);
    fire("R2", 1'b1);
    chk("R2 last free lane0", f(out_pdst, 0), 14);
    chk("R2 last free lane1", f(out_pdst, 1), 15);
    lane(0, 1, 7, 0, 7, 1);
    fire("R9", 1'b0);
    chk("R9 no output on stall", int'(out_valid), 0);
  endtask

  task automatic t_retire();
    ret_valid = 2'b11;
    ret_preg  = {PW'(3), PW'(1)};
    lane(0, 1, 0, 0, 0, 1);
    fire("R11", 1'b0);
    chk("R11 no output same cycle", int'(out_valid), 0);
    lane(0, 1, 7, 3, 5, 1);
    fire("R10", 1'b1);
    chk("R9 stalled write left map", f(out_psrc1, 0), 7);
    chk("R5 src2 mapping", f(out_psrc2, 0), 15);
    chk("R10 first returned", f(out_pdst, 0), 1);
    chk("R4 old after returns", f(out_pold, 0), 13);
    lane(0, 1, 0, 0, 0, 1);
    fire("R10", 1'b1);
    chk("R10 second returned", f(out_pdst, 0), 3);
    lane(0, 1, 0, 0, 0, 1);
    fire("R9", 1'b0);
    chk("R9 empty again", int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_and_first();
    t_bypass();
    t_same_dst();
    t_no_write_lane();
    t_exhaust_stall();
    t_retire();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule